// File: doc/BRIEF.md
# TDM Time-Slot Serial Port

This block is the time-division multiplexed serial port of a digital subscriber line interface. Every 8 kHz frame it sends one 32-bit word and receives one 32-bit word. The word carries both bearer channels, a monitor byte, the signalling pair, a command/indicate nibble and two handshake bits. Each data bit occupies two bit-clock cycles. Frames are counted from a frame sync, and a 3-bit slot number places the 32-bit word in one of eight consecutive slots of the frame.

In slave mode the bit clock, the frame sync and the receive data arrive from outside. All three are resynchronised into the system clock `clk`. In master mode the block divides `clk` down to make its own bit clock, and drives a frame sync together with a second sync that marks the start of the second bearer channel. The transmit line is open-drain, so the block only reports when the line must be pulled low; a pull-up gives the logic 1 level. The mode, the clock select and the slot number are static while the block is out of reset.

Top module: `tdm_slot_port`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `dout_pull_low`, `rx_valid`, `bclk_out`, `fsa_out` and `fsb_out` are all 0.
- R2: In slave mode the first bit-clock rise that sees `fs_in` high, after a rise that saw it low, is rise 0 of a frame. Frame bit n spans rises 2n and 2n+1 counted from rise 0.
- R3: The active slot covers frame bits 32*k to 32*k+31, where k is `slot_sel` (unsigned, bit 2 most significant). Outside that range `dout_pull_low` is 0, so the line is released.
- R4: `tx_word` is captured on the first rise of slot bit 0 and sent most significant bit first. Bits 31:24 are the first bearer byte, 23:16 the second, 15:8 monitor, 7:6 signalling, 5:2 command/indicate and 1:0 handshake. `dout_pull_low` equals the inverse of the current bit and changes only on the first rise of a bit period. A change of `tx_word` after capture has no effect on the current slot.
- R5: `din` is sampled on the second rise of each slot bit and shifted in most significant bit first. One `clk` cycle after the sample of slot bit 31, `rx_word` holds the received word and `rx_valid` is high for exactly one cycle. `din` outside the slot has no effect.
- R6: In master mode `bclk_out` has a half period of HALF_SLOW `clk` cycles when `clk_fast` is 0 and HALF_FAST when it is 1. A frame lasts FRAME_SLOW or FRAME_FAST bit-clock cycles respectively.
- R7: In master mode `fsa_out` rises together with rise 0 of each frame and stays high for one bit period, which is two bit-clock cycles.
- R8: In master mode `fsb_out` is high during frame bit 8, the first bit of the second bearer byte. The slot number is ignored and slot 0 is used.
- R9: In slave mode `bclk_out`, `fsa_out` and `fsb_out` stay 0.
- R10: In slave mode nothing is driven and nothing is received before the first frame sync after reset. A new sync edge restarts counting even if the previous frame has not ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1 = generate clock and syncs, 0 = take them from the pins |
| clk_fast | input | 1 | Master bit clock select: 1 = fast rate, 0 = slow rate |
| slot_sel | input | 3 | Slot number used in slave mode |
| bclk_in | input | 1 | Slave bit clock |
| fs_in | input | 1 | Slave frame sync |
| din | input | 1 | Serial receive data |
| tx_word | input | 32 | Word to transmit in the next slot |
| bclk_out | output | 1 | Master bit clock |
| fsa_out | output | 1 | Master frame sync |
| fsb_out | output | 1 | Master sync marking the second bearer byte |
| dout_pull_low | output | 1 | 1 = pull the open-drain transmit line low |
| rx_word | output | 32 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |

## Verification
The bench builds the block with HALF_SLOW of 6 and HALF_FAST of 2, which keeps the 3:1 rate ratio. Both master frames then last 768 `clk` cycles, so frame period, bit-clock period and second-sync offset can all be measured within a few thousand cycles. NUM_SLOTS stays at 8, so the bench drives slave frames placed in slots 0, 3 and 7, including the slot that ends on the last bit of a full frame. A deliberately cut-short frame shows that a new sync restarts the count.

// File: rtl/tdm_slot_pkg.sv
// Package: field widths of the 32-bit slot word and its packed layout.
// Assumes the field order below is the order on the wire, first field first.
package tdm_slot_pkg;
    localparam int B1_W   = 8;
    localparam int B2_W   = 8;
    localparam int MON_W  = 8;
    localparam int SIG_W  = 2;
    localparam int CI_W   = 4;
    localparam int HS_W   = 2;
    localparam int SLOT_W = B1_W + B2_W + MON_W + SIG_W + CI_W + HS_W;
    // first bit of the second bearer byte, counted from the slot start
    localparam int B2_BIT = B1_W;

    typedef struct packed {
        logic [B1_W-1:0]  bearer1;
        logic [B2_W-1:0]  bearer2;
        logic [MON_W-1:0] monitor;
        logic [SIG_W-1:0] signal;
        logic [CI_W-1:0]  cmd_ind;
        logic [HS_W-1:0]  hshake;
    } slot_word_t;
endpackage

// File: rtl/tdm_bitclk_gen.sv
// Bit-clock source: in master mode divides clk into a bit clock; in slave mode
// resynchronises the bit clock, frame sync and data pins. Gives a one-cycle
// strobe on every bit-clock rise. Assumes the slave bit clock is at most a
// quarter of clk and that HALF_SLOW >= HALF_FAST >= 1.
module tdm_bitclk_gen #(
    parameter int HALF_SLOW = 24,
    parameter int HALF_FAST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic clk_fast,
    input  logic bclk_in,
    input  logic fs_in,
    input  logic din,
    output logic tick,
    output logic fs_lvl,
    output logic din_lvl,
    output logic bclk_out
);
    localparam int DIV_W = $clog2(HALF_SLOW + 1);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim;
    logic             bclk_gen;
    logic [2:0]       s_bclk;
    logic [1:0]       s_fs;
    logic [1:0]       s_din;

    assign div_lim = clk_fast ? DIV_W'(HALF_FAST - 1) : DIV_W'(HALF_SLOW - 1);

    // Divider: toggles the generated bit clock every half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            bclk_gen <= 1'b0;
        end else if (master_en) begin
            if (div_cnt == div_lim) begin
                div_cnt  <= '0;
                bclk_gen <= ~bclk_gen;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // Two-stage resynchronisers with equal depth so the pins stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_bclk <= '0;
            s_fs   <= '0;
            s_din  <= '0;
        end else begin
            s_bclk <= {s_bclk[1:0], bclk_in};
            s_fs   <= {s_fs[0], fs_in};
            s_din  <= {s_din[0], din};
        end
    end

    assign tick     = master_en ? ((div_cnt == div_lim) && !bclk_gen)
                                : (s_bclk[1] && !s_bclk[2]);
    assign fs_lvl   = s_fs[1];
    assign din_lvl  = s_din[1];
    assign bclk_out = master_en && bclk_gen;
endmodule

// File: rtl/tdm_frame_count.sv
// Frame counter: counts bit-clock cycles from the frame start, decides whether
// the next cycle lies in the selected slot, and makes the master syncs.
// Assumes NUM_SLOTS is a power of two and the frame lengths fit in the count.
module tdm_frame_count
    import tdm_slot_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int FRAME_SLOW = 64,
    parameter int FRAME_FAST = 192,
    localparam int SEL_W     = $clog2(NUM_SLOTS),
    localparam int SB_W      = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic             clk_fast,
    input  logic [SEL_W-1:0] slot_sel,
    input  logic             tick,
    input  logic             fs_lvl,
    output logic             in_slot,
    output logic             first_half,
    output logic [SB_W-1:0]  slot_bit,
    output logic             fsa_out,
    output logic             fsb_out
);
    // one bit for the half, SB_W+SEL_W for the bit index, one overflow bit
    localparam int CC_W  = SEL_W + SB_W + 2;
    localparam int IDX_W = CC_W - 2;
    localparam logic [CC_W-1:0] CC_MAX = '1;

    logic [CC_W-1:0]  cc;
    logic [CC_W-1:0]  cc_nxt;
    logic [CC_W-1:0]  frame_lim;
    logic [SEL_W-1:0] eff_slot;
    logic             fs_prev;

    assign frame_lim = clk_fast ? CC_W'(FRAME_FAST - 1) : CC_W'(FRAME_SLOW - 1);
    assign eff_slot  = master_en ? '0 : slot_sel;

    // Next count: wrap in master mode, restart on sync edge and saturate in slave.
    always_comb begin
        if (master_en)
            cc_nxt = (cc >= frame_lim) ? '0 : cc + 1'b1;
        else if (fs_lvl && !fs_prev)
            cc_nxt = '0;
        else if (cc == CC_MAX)
            cc_nxt = CC_MAX;
        else
            cc_nxt = cc + 1'b1;
    end

    // Count register: advances on each bit-clock rise; parked at the top after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc      <= CC_MAX;
            fs_prev <= 1'b0;
        end else if (tick) begin
            cc      <= cc_nxt;
            fs_prev <= fs_lvl;
        end
    end

    assign first_half = ~cc_nxt[0];
    assign slot_bit   = cc_nxt[SB_W:1];
    assign in_slot    = !cc_nxt[CC_W-1] && (cc_nxt[CC_W-2:SB_W+1] == eff_slot);
    assign fsa_out    = master_en && !cc[CC_W-1] && (cc[CC_W-2:1] == '0);
    assign fsb_out    = master_en && !cc[CC_W-1] && (cc[CC_W-2:1] == IDX_W'(B2_BIT));

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        master_en && tick && (cc == frame_lim) |=> (cc == '0)); // R6
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en && tick && fs_lvl && !fs_prev |=> (cc == '0)); // R2
    AST_SYNCS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsa_out && fsb_out)); // R8
endmodule

// File: rtl/tdm_slot_shift.sv
// Slot shifter: loads the transmit word at slot start and shifts it out on the
// first rise of each bit; shifts receive data in on the second rise and
// presents the complete word with a one-cycle strobe.
// Assumes the strobes from the frame counter describe the rise being taken.
module tdm_slot_shift
    import tdm_slot_pkg::*;
#(
    localparam int SB_W = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_slot,
    input  logic              first_half,
    input  logic [SB_W-1:0]   slot_bit,
    input  logic              din_lvl,
    input  logic [SLOT_W-1:0] tx_word,
    output logic              pull_low,
    output logic [SLOT_W-1:0] rx_word,
    output logic              rx_valid
);
    logic [SLOT_W-1:0] tx_sh;
    logic [SLOT_W-1:0] rx_sh;
    logic [SLOT_W-1:0] rx_next;

    assign rx_next = {rx_sh[SLOT_W-2:0], din_lvl};

    // Transmit path: drive a new bit at the start of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            pull_low <= 1'b0;
        end else if (tick && first_half) begin
            if (!in_slot) begin
                pull_low <= 1'b0;
            end else if (slot_bit == '0) begin
                tx_sh    <= tx_word << 1;
                pull_low <= ~tx_word[SLOT_W-1];
            end else begin
                tx_sh    <= tx_sh << 1;
                pull_low <= ~tx_sh[SLOT_W-1];
            end
        end
    end

    // Receive path: sample mid-bit, publish the word after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tick && !first_half && in_slot) begin
                rx_sh <= rx_next;
                if (slot_bit == SB_W'(SLOT_W - 1)) begin
                    rx_word  <= rx_next;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    AST_DRIVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_low) |-> $past(tick)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5
    AST_VALID_MIDBIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick && in_slot && !first_half)); // R5
endmodule

// File: rtl/tdm_slot_port.sv
// Top: time-slot serial port. Wires the bit-clock source, frame counter and
// slot shifter. Assumes master_en, clk_fast and slot_sel are static while
// out of reset.
module tdm_slot_port
    import tdm_slot_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int HALF_SLOW  = 24,
    parameter int HALF_FAST  = 8,
    parameter int FRAME_SLOW = 64,
    parameter int FRAME_FAST = 192,
    localparam int SEL_W     = $clog2(NUM_SLOTS),
    localparam int SB_W      = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              clk_fast,
    input  logic [SEL_W-1:0]  slot_sel,
    input  logic              bclk_in,
    input  logic              fs_in,
    input  logic              din,
    input  logic [SLOT_W-1:0] tx_word,
    output logic              bclk_out,
    output logic              fsa_out,
    output logic              fsb_out,
    output logic              dout_pull_low,
    output logic [SLOT_W-1:0] rx_word,
    output logic              rx_valid
);
    logic            tick;
    logic            fs_lvl;
    logic            din_lvl;
    logic            in_slot;
    logic            first_half;
    logic [SB_W-1:0] slot_bit;

    tdm_bitclk_gen #(
        .HALF_SLOW (HALF_SLOW),
        .HALF_FAST (HALF_FAST)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .clk_fast  (clk_fast),
        .bclk_in   (bclk_in),
        .fs_in     (fs_in),
        .din       (din),
        .tick      (tick),
        .fs_lvl    (fs_lvl),
        .din_lvl   (din_lvl),
        .bclk_out  (bclk_out)
    );

    tdm_frame_count #(
        .NUM_SLOTS  (NUM_SLOTS),
        .FRAME_SLOW (FRAME_SLOW),
        .FRAME_FAST (FRAME_FAST)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_en  (master_en),
        .clk_fast   (clk_fast),
        .slot_sel   (slot_sel),
        .tick       (tick),
        .fs_lvl     (fs_lvl),
        .in_slot    (in_slot),
        .first_half (first_half),
        .slot_bit   (slot_bit),
        .fsa_out    (fsa_out),
        .fsb_out    (fsb_out)
    );

    tdm_slot_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .in_slot    (in_slot),
        .first_half (first_half),
        .slot_bit   (slot_bit),
        .din_lvl    (din_lvl),
        .tx_word    (tx_word),
        .pull_low   (dout_pull_low),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid)
    );

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> !bclk_out && !fsa_out && !fsb_out); // R9
endmodule

// File: tb/tb_tdm_slot_port.sv
module tb_tdm_slot_port;
    localparam int HS = 6;
    localparam int HF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic        clk_fast = 1'b0;
    logic [2:0]  slot_sel = '0;
    logic        bclk_in = 1'b0;
    logic        fs_in = 1'b0;
    logic        din = 1'b1;
    logic [31:0] tx_word = '0;
    logic        bclk_out, fsa_out, fsb_out, dout_pull_low, rx_valid;
    logic [31:0] rx_word;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mon_en = 1'b0;
    bit slave_clk_seen = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_w;

    tdm_slot_port #(.HALF_SLOW(HS), .HALF_FAST(HF)) dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .clk_fast(clk_fast),
        .slot_sel(slot_sel), .bclk_in(bclk_in), .fs_in(fs_in), .din(din),
        .tx_word(tx_word), .bclk_out(bclk_out), .fsa_out(fsa_out),
        .fsb_out(fsb_out), .dout_pull_low(dout_pull_low), .rx_word(rx_word),
        .rx_valid(rx_valid)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every received word must match the next expected one.
    always @(negedge clk) begin
        if (rst_n && !master_en && (bclk_out || fsa_out || fsb_out))
            slave_clk_seen = 1'b1;
        if (rst_n && mon_en && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected rx_valid", rx_word, 32'h0);
            end else begin
                exp_w = exp_q.pop_front();
                chk(rx_word == exp_w, "R5", "received word", rx_word, exp_w);
            end
        end
    end

    task automatic do_reset(input bit m, input bit f, input logic [2:0] k);
        @(negedge clk);
        rst_n = 1'b0; master_en = m; clk_fast = f; slot_sel = k;
        bclk_in = 1'b0; fs_in = 1'b0; din = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Work done at bit-clock rise r of a frame whose slot is k.
    task automatic rise_actions(input int r, input int k, input logic [31:0] tx,
                                input logic [31:0] rx, input logic [31:0] tx_alt,
                                inout int errs);
        int  b, j;
        bit  ins;
        logic e;
        b   = r / 2;
        j   = b - 32 * k;
        ins = (j >= 0) && (j < 32);
        if (r % 2 == 0) begin
            din = ins ? rx[31 - j] : b[0];
            if (ins && j == 16) tx_word = tx_alt;
        end else begin
            e = ins ? ~tx[31 - j] : 1'b0;
            if (dout_pull_low !== e) errs++;
        end
    endtask

    // Driver: one slave frame of nr rises, pushing the expected word.
    task automatic slave_frame(input int k, input int nr, input logic [31:0] tx,
                               input logic [31:0] rx, input logic [31:0] tx_alt,
                               output int errs);
        errs = 0;
        slot_sel = k[2:0];
        tx_word  = tx;
        if (2 * (32 * k + 32) <= nr) exp_q.push_back(rx);
        for (int r = 0; r < nr; r++) begin
            @(negedge clk);
            bclk_in = 1'b0;
            fs_in   = (r == 0);
            repeat (3) @(negedge clk);
            @(negedge clk);
            bclk_in = 1'b1;
            rise_actions(r, k, tx, rx, tx_alt, errs);
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        bclk_in = 1'b0;
    endtask

    // Driver: follows the generated clock through slot 0 of one master frame.
    task automatic master_frame(input logic [31:0] tx, input logic [31:0] rx,
                                input logic [31:0] tx_alt, output int errs);
        errs = 0;
        tx_word = tx;
        @(posedge fsa_out);
        exp_q.push_back(rx);
        mon_en = 1'b1;
        for (int r = 0; r < 64; r++) begin
            if (r > 0) @(posedge bclk_out);
            @(negedge clk);
            rise_actions(r, 0, tx, rx, tx_alt, errs);
        end
        repeat (2) @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic master_timing(input bit f, input int h);
        int t0, t1, t2, t3, a, b;
        @(posedge fsa_out); @(negedge clk); t0 = cyc;
        @(negedge fsa_out); @(negedge clk); t3 = cyc;
        @(posedge fsb_out); @(negedge clk); t1 = cyc;
        @(posedge fsa_out); @(negedge clk); t2 = cyc;
        @(posedge bclk_out); @(negedge clk); a = cyc;
        @(posedge bclk_out); @(negedge clk); b = cyc;
        chk(b - a == 2 * h, "R6", "bit clock period", b - a, 2 * h);
        chk(t2 - t0 == (f ? 192 : 64) * 2 * h, "R6", "frame period",
            t2 - t0, (f ? 192 : 64) * 2 * h);
        chk(t3 - t0 == 4 * h, "R7", "frame sync width", t3 - t0, 4 * h);
        chk(t1 - t0 == 16 * 2 * h, "R8", "second sync offset", t1 - t0, 32 * h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired, R1 to R10 incomplete: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int errs, seen;
        // R1: reset state
        do_reset(1'b0, 1'b0, 3'd0);
        @(negedge clk);
        chk({bclk_out, fsa_out, fsb_out, dout_pull_low, rx_valid} == 5'b0, "R1",
            "outputs after reset", {bclk_out, fsa_out, fsb_out, dout_pull_low, rx_valid}, 0);
        mon_en = 1'b1;

        // R10: clock without sync drives nothing and receives nothing
        seen = 0;
        for (int r = 0; r < 100; r++) begin
            @(negedge clk); bclk_in = 1'b0; din = r[1];
            repeat (4) @(negedge clk); bclk_in = 1'b1;
            repeat (4) begin @(negedge clk); if (dout_pull_low) seen++; end
        end
        chk(seen == 0, "R10", "line driven before first sync", seen, 0);

        // R2/R4/R5: slot 0, word change mid-slot must be ignored
        slave_frame(0, 64, 32'hA5C3_0F96, 32'h1234_5678, 32'hFFFF_FFFF, errs);
        chk(errs == 0, "R4", "slot 0 transmit stream", errs, 0);
        // R10: frame cut short by a new sync
        slave_frame(0, 40, 32'h0000_0001, 32'hDEAD_BEEF, 32'h0, errs);
        chk(errs == 0, "R10", "truncated frame stream", errs, 0);
        slave_frame(0, 70, 32'h8000_0000, 32'hC0DE_CAFE, 32'h7777_7777, errs);
        chk(errs == 0, "R2", "frame restarted by sync", errs, 0);
        // R3: slots 3 and 7
        slave_frame(3, 260, 32'h5A5A_F00F, 32'h8765_4321, 32'h0, errs);
        chk(errs == 0, "R3", "slot 3 transmit stream", errs, 0);
        slave_frame(7, 512, 32'h3C00_00FF, 32'hF0E1_D2C3, 32'hAAAA_5555, errs);
        chk(errs == 0, "R3", "slot 7 transmit stream", errs, 0);
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "words outstanding after slave frames", exp_q.size(), 0);
        chk(!slave_clk_seen, "R9", "master outputs active in slave mode", slave_clk_seen, 0);
        mon_en = 1'b0;

        // R6/R7/R8: master, slow clock, slot number ignored
        do_reset(1'b1, 1'b0, 3'd5);
        master_timing(1'b0, HS);
        master_frame(32'h9ABC_DEF0, 32'h0F1E_2D3C, 32'h0, errs);
        chk(errs == 0, "R8", "master slow slot 0 stream", errs, 0);

        // R6/R7/R8: master, fast clock
        do_reset(1'b1, 1'b1, 3'd2);
        master_timing(1'b1, HF);
        master_frame(32'h0123_4567, 32'hBEEF_0001, 32'h5555_AAAA, errs);
        chk(errs == 0, "R8", "master fast slot 0 stream", errs, 0);
        chk(exp_q.size() == 0, "R5", "words outstanding at end", exp_q.size(), 0);

        do_reset(1'b0, 1'b0, 3'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule